// File: doc/BRIEF.md
# Four-Bank Row-Cached DRAM Model

This block is a clocked behavioural model of a DRAM whose storage is split into four banks. Each bank owns a single-row SRAM register that serves as its cache, together with a tag holding the last row that was read into it. The row and column share one address bus. A row-activate pulse presents the row, and later cycles present columns. Every read is served from the row register of the addressed bank, never straight from the array. A read that misses first copies the array row into that register. Writes always go to the array. They also go to the row register only when the open row is the cached one.

An active-low hit pin reports, one cycle after activation, whether data will come early (hit) or late (miss). A column-hold control switches between static-column operation and a held column. An output hold keeps read data on the pins, and an output enable gates them. A refresh request advances an internal refresh row counter without stalling cache reads. The array depth per bank is a power-of-two parameter. Rows whose tags differ only above that depth share array storage.

Top module: `banked_rowcache_dram`

## Requirements
- R1: After reset, hit_n is 1, data_rdy is 0, dout is 0 and ref_row is 0. Every bank tag is invalid, so the first activation of each bank reports a miss.
- R2: An accepted row_act decodes bank = addr[9:8] and tag = {addr[10], addr[7:0]}. On the following edge hit_n goes to 0 if that bank holds a valid tag equal to it and to 1 otherwise, and it keeps that value until the next accepted row_act.
- R3: On a read hit, a column presented in the cycle after activation yields that column's byte on dout with data_rdy = 1 after the next edge.
- R4: On a read miss, data_rdy stays 0 for LOAD_LAT extra cycles while the array row is copied into the bank's row register, and the bank tag takes the new row. The first byte then appears LOAD_LAT cycles later than on a hit. A row_act during the copy is ignored.
- R5: Within an open read page, a new column every cycle, in order or not, gives a new byte every cycle with one cycle of latency.
- R6: In a write access (wr_en = 1 at row_act), each cycle with wr_en = 1 stores din at the current column in the array. When the access hit, it stores it in the row register too, so a later hit read returns the new byte.
- R7: A write miss leaves the row register and its tag unchanged. A later read of the cached row still hits and returns the old byte, and a later read of the written row misses and returns the written byte.
- R8: While col_open = 1 the column follows addr[7:0] each cycle. While col_open = 0 the last column sampled with col_open = 1 is used, and address changes have no effect until col_open returns to 1.
- R9: Each cycle with refresh_req = 1 advances ref_row by one, modulo 2^REF_W. Without it ref_row holds. Reads in flight keep their data and latency.
- R10: oe_n = 1 forces dout to 0 without disturbing the read data, which shows again once oe_n = 0.
- R11: While out_hold = 1, dout and data_rdy keep their values whatever column is presented.
- R12: A miss fill in one bank does not disturb the row register or tag of any other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_act | input | 1 | Row activate; addr carries a row address this cycle |
| wr_en | input | 1 | At row_act: 1 opens a write access. Afterwards: write strobe |
| addr | input | 11 | Multiplexed row/column address |
| col_open | input | 1 | 1 = column follows addr, 0 = column held |
| out_hold | input | 1 | Hold read data and data_rdy |
| oe_n | input | 1 | Active-low output enable |
| din | input | 8 | Write data |
| refresh_req | input | 1 | Refresh step request |
| dout | output | 8 | Read data |
| hit_n | output | 1 | Active-low page hit of the last activation |
| data_rdy | output | 1 | dout holds a byte read from the row register |
| ref_row | output | REF_W | Refresh row counter |

## Verification
The bench attacks cache coherence across a write miss followed by reads of both rows. A design that fills or retags on a write miss returns the new byte where the old one is due, and a design that skips the array write returns stale data after the refill. Miss latency is pinned cycle by cycle, so an early data_rdy or a fill one cycle short shows up as wrong or garbage bytes. The column hold and output hold are driven with changing addresses, so a leaky latch shows up as the wrong byte. Banks are interleaved to catch a fill that overwrites a neighbour's tag. The refresh counter is stepped through its wrap while reads continue, which exposes any stall or count error.

// File: rtl/rcd_pkg.sv
`timescale 1ns/1ps
package rcd_pkg;
    localparam int DATA_W = 8;
    localparam int COL_W  = 8;
    localparam int BANK_W = 2;
    localparam int NBANK  = 1 << BANK_W;
    localparam int ADDR_W = 11;
    localparam int TAG_W  = ADDR_W - BANK_W;
    localparam int COLS   = 1 << COL_W;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [COLS-1:0][DATA_W-1:0] row_t;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [TAG_W-1:0]  tag;
    } row_sel_t;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        row_sel_t  sel;
        logic      hit;
    } access_t;

    // Bank bits sit just above the column field; the tag is everything else.
    function automatic row_sel_t split_row(input logic [ADDR_W-1:0] a);
        row_sel_t s;
        s.bank = a[COL_W +: BANK_W];
        s.tag  = {a[ADDR_W-1:COL_W+BANK_W], a[COL_W-1:0]};
        return s;
    endfunction
endpackage

// File: rtl/rcd_tag_store.sv
`timescale 1ns/1ps
module rcd_tag_store
    import rcd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  row_sel_t look,
    output logic     look_hit,
    input  logic     upd_en,
    input  row_sel_t upd
);
    logic [NBANK-1:0] hit_vec;
    logic [NBANK-1:0] upd_vec;

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            logic             vld_q;
            logic [TAG_W-1:0] tag_q;

            assign upd_vec[b] = upd_en && (upd.bank == BANK_W'(b));
            assign hit_vec[b] = vld_q && (tag_q == look.tag);

            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_q <= 1'b0;
                    tag_q <= '0;
                end else if (upd_vec[b]) begin
                    vld_q <= 1'b1;
                    tag_q <= upd.tag;
                end
            end
        end
    endgenerate

    assign look_hit = hit_vec[look.bank];

    AST_ONE_TAG_UPDATE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(upd_vec)); // R12
    AST_UPDATED_TAG_HITS: assert property (@(posedge clk) disable iff (rst)
        (upd_en && look == upd) |=> look_hit || !$stable(look)); // R4
endmodule

// File: rtl/rcd_array.sv
`timescale 1ns/1ps
module rcd_array
    import rcd_pkg::*;
#(
    parameter int ROWS_PER_BANK = 2,
    parameter int REF_W         = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [BANK_W-1:0]     sel_bank,
    input  logic [(ROWS_PER_BANK > 1 ? $clog2(ROWS_PER_BANK) : 1)-1:0] sel_row,
    input  logic [COL_W-1:0]      wr_col,
    input  byte_t                 wr_data,
    output row_t                  rd_row,
    input  logic                  refresh_req,
    output logic [REF_W-1:0]      ref_row
);
    localparam int RI_W  = (ROWS_PER_BANK > 1) ? $clog2(ROWS_PER_BANK) : 1;
    localparam int DEPTH = NBANK * (1 << RI_W);

    row_t mem [DEPTH];
    logic [BANK_W+RI_W-1:0] idx;

    assign idx    = {sel_bank, sel_row};
    assign rd_row = mem[idx];

    always_ff @(posedge clk) begin
        if (wr_en) mem[idx][wr_col] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)              ref_row <= '0;
        else if (refresh_req) ref_row <= ref_row + 1'b1;
    end

    AST_REF_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        refresh_req |=> ref_row != $past(ref_row)); // R9
    AST_REF_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !refresh_req |=> $stable(ref_row)); // R9
endmodule

// File: rtl/rcd_row_cache.sv
`timescale 1ns/1ps
module rcd_row_cache
    import rcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_en,
    input  logic [BANK_W-1:0] bank,
    input  row_t              fill_row,
    input  logic              wr_en,
    input  logic [COL_W-1:0]  col,
    input  byte_t             wr_data,
    input  logic              rd_fire,
    input  logic              out_hold,
    input  logic              oe_n,
    output byte_t             dout,
    output logic              rdy
);
    byte_t rd_byte [NBANK];
    byte_t q_r;

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_line
            row_t line_q;
            logic sel;
            assign sel        = (bank == BANK_W'(b));
            assign rd_byte[b] = line_q[col];

            always_ff @(posedge clk) begin
                if (fill_en && sel)     line_q      <= fill_row;
                else if (wr_en && sel)  line_q[col] <= wr_data;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
            rdy <= 1'b0;
        end else if (!out_hold) begin
            rdy <= rd_fire;
            if (rd_fire) q_r <= rd_byte[bank];
        end
    end

    assign dout = oe_n ? '0 : q_r;

    AST_HOLD_KEEPS_Q: assert property (@(posedge clk) disable iff (rst)
        out_hold |=> $stable(q_r) && $stable(rdy)); // R11
    AST_NO_RDY_AFTER_FILL: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !out_hold) |=> !rdy); // R4
endmodule

// File: rtl/rcd_ctrl.sv
`timescale 1ns/1ps
module rcd_ctrl
    import rcd_pkg::*;
#(
    parameter int LOAD_LAT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              row_act,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              col_open,
    input  logic              look_hit,
    output row_sel_t          look,
    output access_t           act,
    output logic              fill_en,
    output logic              rd_fire,
    output logic              wr_fire,
    output logic              hit_n,
    output logic [COL_W-1:0]  col_eff
);
    localparam int CNT_W = $clog2(LOAD_LAT + 1);

    logic [CNT_W-1:0] cnt;
    logic [COL_W-1:0] col_lat;
    logic             loading;
    logic             acc_go;

    assign look   = split_row(addr);
    assign acc_go = row_act && !loading;

    always_ff @(posedge clk) begin
        if (rst) begin
            act     <= '{kind: ACC_IDLE, sel: '0, hit: 1'b0};
            hit_n   <= 1'b1;
            loading <= 1'b0;
            cnt     <= '0;
        end else if (acc_go) begin
            act.kind <= wr_en ? ACC_WRITE : ACC_READ;
            act.sel  <= look;
            act.hit  <= look_hit;
            hit_n    <= !look_hit;
            if (!wr_en && !look_hit) begin
                loading <= 1'b1;
                cnt     <= CNT_W'(LOAD_LAT - 1);
            end
        end else if (loading) begin
            if (cnt == '0) begin
                loading <= 1'b0;
                act.hit <= 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           col_lat <= '0;
        else if (col_open) col_lat <= addr[COL_W-1:0];
    end

    assign col_eff = col_open ? addr[COL_W-1:0] : col_lat;
    assign fill_en = loading && (cnt == '0);
    assign rd_fire = (act.kind == ACC_READ) && !loading && !row_act;
    assign wr_fire = (act.kind == ACC_WRITE) && wr_en && !row_act;

    AST_READ_MISS_LOADS: assert property (@(posedge clk) disable iff (rst)
        (acc_go && !wr_en && !look_hit) |=> loading); // R4
    AST_WRITE_NEVER_LOADS: assert property (@(posedge clk) disable iff (rst)
        (acc_go && wr_en) |=> !loading); // R7
    AST_HITN_STEADY: assert property (@(posedge clk) disable iff (rst)
        !acc_go |=> $stable(hit_n)); // R2
    AST_IGNORE_ACT_IN_FILL: assert property (@(posedge clk) disable iff (rst)
        (loading && row_act) |=> $stable(act.sel)); // R4
endmodule

// File: rtl/banked_rowcache_dram.sv
`timescale 1ns/1ps
module banked_rowcache_dram
    import rcd_pkg::*;
#(
    parameter int ROWS_PER_BANK = 2,
    parameter int LOAD_LAT      = 3,
    parameter int REF_W         = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 row_act,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 col_open,
    input  logic                 out_hold,
    input  logic                 oe_n,
    input  logic [DATA_W-1:0]    din,
    input  logic                 refresh_req,
    output logic [DATA_W-1:0]    dout,
    output logic                 hit_n,
    output logic                 data_rdy,
    output logic [REF_W-1:0]     ref_row
);
    localparam int RI_W = (ROWS_PER_BANK > 1) ? $clog2(ROWS_PER_BANK) : 1;

    row_sel_t         look;
    access_t          act;
    logic             look_hit;
    logic             fill_en;
    logic             rd_fire;
    logic             wr_fire;
    logic [COL_W-1:0] col_eff;
    row_t             arr_row;

    rcd_ctrl #(.LOAD_LAT(LOAD_LAT)) u_ctrl (
        .clk(clk), .rst(rst), .row_act(row_act), .wr_en(wr_en), .addr(addr),
        .col_open(col_open), .look_hit(look_hit), .look(look), .act(act),
        .fill_en(fill_en), .rd_fire(rd_fire), .wr_fire(wr_fire),
        .hit_n(hit_n), .col_eff(col_eff)
    );

    rcd_tag_store u_tags (
        .clk(clk), .rst(rst), .look(look), .look_hit(look_hit),
        .upd_en(fill_en), .upd(act.sel)
    );

    rcd_array #(.ROWS_PER_BANK(ROWS_PER_BANK), .REF_W(REF_W)) u_array (
        .clk(clk), .rst(rst), .wr_en(wr_fire), .sel_bank(act.sel.bank),
        .sel_row(act.sel.tag[RI_W-1:0]), .wr_col(col_eff), .wr_data(din),
        .rd_row(arr_row), .refresh_req(refresh_req), .ref_row(ref_row)
    );

    rcd_row_cache u_cache (
        .clk(clk), .rst(rst), .fill_en(fill_en), .bank(act.sel.bank),
        .fill_row(arr_row), .wr_en(wr_fire && act.hit), .col(col_eff),
        .wr_data(din), .rd_fire(rd_fire), .out_hold(out_hold), .oe_n(oe_n),
        .dout(dout), .rdy(data_rdy)
    );

    AST_WRITE_HIT_COHERENT: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && !hit_n) |=> $past(act.hit)); // R6
endmodule

// File: tb/sim_banked_rowcache_dram.sv
`timescale 1ns/1ps
module sim_banked_rowcache_dram;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        row_act = 1'b0, wr_en = 1'b0, col_open = 1'b1;
    logic        out_hold = 1'b0, oe_n = 1'b0, refresh_req = 1'b0;
    logic [10:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        hit_n, data_rdy;
    logic [3:0]  ref_row;

    banked_rowcache_dram #(.ROWS_PER_BANK(2), .LOAD_LAT(LAT), .REF_W(4)) u0 (
        .clk(clk), .rst(rst), .row_act(row_act), .wr_en(wr_en), .addr(addr),
        .col_open(col_open), .out_hold(out_hold), .oe_n(oe_n), .din(din),
        .refresh_req(refresh_req), .dout(dout), .hit_n(hit_n),
        .data_rdy(data_rdy), .ref_row(ref_row)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;

    // kind: 0 data byte with data_rdy=1, 1 hit_n, 2 data_rdy low, 3 ref_row
    typedef struct {
        int         due;
        int         kind;
        logic [7:0] val;
        string      req;
    } exp_t;
    exp_t sbq[$];

    logic [7:0] arr  [4][2][256];
    logic [7:0] cdat [4][256];
    int         ctag [4];
    bit         cval [4];
    int         cur_b, cur_r;
    bit         cur_hit;
    int         ref_exp = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act_v, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)",
                     req, what, act_v, exp_v, cyc);
        end
    endtask

    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            exp_t e;
            e = sbq.pop_front();
            case (e.kind)
                0: begin
                    chk(data_rdy === 1'b1, e.req, "data_rdy", int'(data_rdy), 1);
                    chk(dout === e.val, e.req, "dout", int'(dout), int'(e.val));
                end
                1: chk(hit_n === e.val[0], e.req, "hit_n", int'(hit_n), int'(e.val[0]));
                2: chk(data_rdy === 1'b0, e.req, "data_rdy", int'(data_rdy), 0);
                default: chk(ref_row === e.val[3:0], e.req, "ref_row",
                             int'(ref_row), int'(e.val[3:0]));
            endcase
        end
    end

    function automatic logic [7:0] pat(input int b, input int r, input int c);
        return 8'(c * 7 + r * 91 + b * 29 + 3);
    endfunction

    task automatic step();
        @(posedge clk);
        #3;
    endtask

    task automatic push(input int d, input int k, input logic [7:0] v, input string r);
        exp_t e;
        e.due = d; e.kind = k; e.val = v; e.req = r;
        sbq.push_back(e);
    endtask

    task automatic open_row(input int b, input int r, input bit wr, input string req);
        bit h;
        h = cval[b] && (ctag[b] == r);
        row_act = 1'b1;
        wr_en   = wr;
        addr    = 11'((b << 8) | r);
        push(cyc + 1, 1, {7'b0, !h}, req);
        step();
        row_act = 1'b0;
        wr_en   = 1'b0;
        cur_b = b; cur_r = r; cur_hit = h;
        if (!wr && !h) begin
            for (int i = 0; i < LAT; i++) begin
                push(cyc + 1, 2, 8'h00, "R4");
                step();
            end
            for (int c = 0; c < 256; c++) cdat[b][c] = arr[b][r][c];
            ctag[b] = r; cval[b] = 1'b1; cur_hit = 1'b1;
        end
    endtask

    task automatic write_col(input int c, input logic [7:0] d);
        addr  = 11'(c);
        wr_en = 1'b1;
        din   = d;
        step();
        wr_en = 1'b0;
        arr[cur_b][cur_r][c] = d;
        if (cur_hit) cdat[cur_b][c] = d;
    endtask

    task automatic read_exp(input int c, input logic [7:0] v, input string req);
        addr = 11'(c);
        push(cyc + 1, 0, v, req);
        step();
    endtask

    task automatic read_col(input int c, input string req);
        read_exp(c, cdat[cur_b][c], req);
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int b = 0; b < 4; b++) begin
            cval[b] = 1'b0; ctag[b] = 0;
            for (int c = 0; c < 256; c++) begin
                cdat[b][c] = '0;
                arr[b][0][c] = '0;
                arr[b][1][c] = '0;
            end
        end
        repeat (3) step();
        rst = 1'b0;
        // R1 reset state
        chk(hit_n === 1'b1, "R1", "hit_n", int'(hit_n), 1);
        chk(data_rdy === 1'b0, "R1", "data_rdy", int'(data_rdy), 0);
        chk(dout === 8'h00, "R1", "dout", int'(dout), 0);
        chk(ref_row === 4'h0, "R1", "ref_row", int'(ref_row), 0);

        // R1: first accesses miss; preload array through write misses
        open_row(0, 0, 1'b1, "R1");
        for (int c = 0; c < 8; c++) write_col(c, pat(0, 0, c));
        open_row(0, 1, 1'b1, "R1");
        write_col(4, pat(0, 1, 4));
        write_col(5, pat(0, 1, 5));
        write_col(10, pat(0, 1, 10));
        write_col(20, pat(0, 1, 20));

        // R4 read miss with fill latency, R5 page reads
        open_row(0, 0, 1'b0, "R4");
        read_col(3, "R4");
        for (int c = 0; c < 8; c++) read_col(c, "R5");
        read_col(7, "R5");
        read_col(1, "R5");
        read_col(6, "R5");

        // R2 hit reported, R3 hit data one cycle after column
        open_row(0, 0, 1'b0, "R2");
        read_col(2, "R3");

        // R6 write hit updates the row register
        open_row(0, 0, 1'b1, "R6");
        write_col(4, 8'h3C);
        open_row(0, 0, 1'b0, "R6");
        read_col(4, "R6");

        // R7 write miss: cache keeps old byte, array gets new one
        open_row(0, 1, 1'b1, "R7");
        write_col(4, 8'h77);
        open_row(0, 0, 1'b0, "R7");
        read_col(4, "R7");
        open_row(0, 1, 1'b0, "R7");
        read_col(4, "R7");
        read_col(5, "R7");

        // R12 banks independent
        open_row(1, 0, 1'b1, "R12");
        write_col(9, pat(1, 0, 9));
        open_row(1, 0, 1'b0, "R12");
        read_col(9, "R12");
        open_row(0, 1, 1'b0, "R12");
        read_col(4, "R12");

        // R8 column hold
        col_open = 1'b1;
        read_col(10, "R8");
        col_open = 1'b0;
        read_exp(10, cdat[0][10], "R8");
        read_exp(20, cdat[0][10], "R8");
        read_exp(5, cdat[0][10], "R8");
        col_open = 1'b1;
        read_col(20, "R8");

        // R11 output hold
        out_hold = 1'b1;
        read_exp(5, cdat[0][20], "R11");
        read_exp(4, cdat[0][20], "R11");
        out_hold = 1'b0;
        read_col(4, "R11");

        // R10 output enable
        oe_n = 1'b1;
        read_exp(5, 8'h00, "R10");
        oe_n = 1'b0;
        read_col(5, "R10");

        // R9 refresh during page reads, then hold, then wrap
        for (int i = 0; i < 3; i++) begin
            refresh_req = 1'b1;
            ref_exp = (ref_exp + 1) % 16;
            push(cyc + 1, 3, 8'(ref_exp), "R9");
            read_col((i == 1) ? 10 : 20, "R9");
        end
        refresh_req = 1'b0;
        push(cyc + 1, 3, 8'(ref_exp), "R9");
        read_col(4, "R9");
        for (int i = 0; i < 13; i++) begin
            refresh_req = 1'b1;
            ref_exp = (ref_exp + 1) % 16;
            push(cyc + 1, 3, 8'(ref_exp), "R9");
            step();
        end
        refresh_req = 1'b0;
        push(cyc + 1, 3, 8'(ref_exp), "R9");
        read_col(5, "R9");

        repeat (4) step();
        if (sbq.size() != 0)
            chk(1'b0, "R3", "scoreboard leftover", sbq.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule